// File: doc/BRIEF.md
# Signed Complement Load Unit

This unit carries out three register-to-register operations on two's-complement integers: complement (arithmetic negation), load negative (force the value to be zero or below) and load positive (force the value to be zero or above). A fourth select code copies the operand unchanged. Each accepted operation returns a registered result, a two-bit condition code that classifies the result, and a one-cycle interruption request when the operation overflowed and the overflow mask bit was set. The unit sits between a register read port and a write-back stage. It does no register access, no instruction decode and no interrupt handling.

A two-state machine tracks the output stage. In state ST_IDLE no result is presented. In state ST_EMIT the registered result, the condition code and the request pulse are valid. Both states move to ST_EMIT when `in_valid` is high and to ST_IDLE when it is low. Reset enters ST_IDLE. The result and condition code registers load only when `in_valid` is high, so they keep their last values while no operation is presented.

Top module: `scl_unit`

## Requirements
- R1: After reset, `out_valid`, `irq`, `result` and `cond_code` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, so the latency is one cycle.
- R3: With `op_sel` = 2'b00 (complement), `result` is the negation of `operand` modulo 2^WIDTH, so 0 and the most negative value (only the sign bit set) come out unchanged. Complementing the most negative value is an overflow.
- R4: With `op_sel` = 2'b01 (load negative), `result` is minus the absolute value of `operand`: positive inputs are negated, and zero and negative inputs pass unchanged. The condition code is never 2 or 3.
- R5: With `op_sel` = 2'b10 (load positive), negative inputs are negated and the others pass unchanged. The most negative value returns itself and is an overflow.
- R6: With `op_sel` = 2'b11 (pass-through), `result` equals `operand` and no overflow is raised.
- R7: `cond_code` is 3 on overflow. Otherwise it is 0 for a zero result, 1 for a negative result and 2 for a positive result.
- R8: `irq` is high for one cycle, alongside `out_valid`, exactly when the operation overflowed and `ovf_mask` was 1 with that operation.
- R9: When `ovf_mask` is 0, an overflowing operation still gives condition code 3, but `irq` stays low.
- R10: In a cycle after one with `in_valid` low, `result` and `cond_code` hold their previous values and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 2 | 00 complement, 01 load negative, 10 load positive, 11 pass-through |
| operand | input | WIDTH | Signed operand |
| ovf_mask | input | 1 | Overflow interruption enable |
| out_valid | output | 1 | Result valid (ST_EMIT) |
| result | output | WIDTH | Registered signed result |
| cond_code | output | 2 | 0 zero, 1 negative, 2 positive, 3 overflow |
| irq | output | 1 | Overflow interruption request pulse |

## Verification
The bench builds the unit with the default WIDTH of 32. At that width the sign-bit boundaries 0x80000000, 0x7FFFFFFF, 0xFFFFFFFF and 0 are hit directly under every select code. Random operands, mixed with those corner values and with both mask settings, cover the sign classes, overflow with and without the mask, back-to-back operations and idle gaps.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [1:0] {
        OP_CMP  = 2'b00,
        OP_NEG  = 2'b01,
        OP_POS  = 2'b10,
        OP_PASS = 2'b11
    } scl_op_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } scl_cc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } scl_state_e;
endpackage

// File: rtl/scl_datapath.sv
module scl_datapath
    import scl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  scl_op_e          op,
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] res,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] negated;
    logic             is_neg;
    logic             is_most_neg;

    assign negated     = ~opnd + {{(WIDTH-1){1'b0}}, 1'b1};
    assign is_neg      = opnd[WIDTH-1];
    assign is_most_neg = (opnd == MOST_NEG);

    always_comb begin
        res = opnd;
        ovf = 1'b0;
        unique case (op)
            OP_CMP: begin
                res = negated;
                ovf = is_most_neg;
            end
            OP_NEG: begin
                res = is_neg ? opnd : negated;
            end
            OP_POS: begin
                res = is_neg ? negated : opnd;
                ovf = is_most_neg;
            end
            OP_PASS: begin
                res = opnd;
            end
            default: begin
                res = opnd;
            end
        endcase
    end
endmodule

// File: rtl/scl_ccgen.sv
module scl_ccgen
    import scl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    input  logic             ovf,
    output scl_cc_e          cc
);
    always_comb begin
        if (ovf)
            cc = CC_OVF;
        else if (res == '0)
            cc = CC_ZERO;
        else if (res[WIDTH-1])
            cc = CC_NEG;
        else
            cc = CC_POS;
    end
endmodule

// File: rtl/scl_unit.sv
module scl_unit
    import scl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] operand,
    input  logic             ovf_mask,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic [1:0]       cond_code,
    output logic             irq
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    scl_state_e       state_q, state_d;
    logic [WIDTH-1:0] res_c;
    logic             ovf_c;
    scl_cc_e          cc_c;
    logic [WIDTH-1:0] result_q;
    scl_cc_e          cc_q;
    logic             irq_q;

    scl_datapath #(.WIDTH(WIDTH)) u_datapath (
        .op   (scl_op_e'(op_sel)),
        .opnd (operand),
        .res  (res_c),
        .ovf  (ovf_c)
    );

    scl_ccgen #(.WIDTH(WIDTH)) u_ccgen (
        .res (res_c),
        .ovf (ovf_c),
        .cc  (cc_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            cc_q     <= CC_ZERO;
            irq_q    <= 1'b0;
        end else if (in_valid) begin
            result_q <= res_c;
            cc_q     <= cc_c;
            irq_q    <= ovf_c & ovf_mask;
        end else begin
            irq_q    <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign result    = result_q;
    assign cond_code = cc_q;
    assign irq       = irq_q;

    // R2: one-cycle latency of the valid strobe
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: load negative never yields positive or overflow
    a_r4_neg_no_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b01) |=> (cond_code == 2'd0 || cond_code == 2'd1));

    // R5: load positive of anything but the most negative value is non-negative
    a_r5_pos_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b10 && operand != MOST_NEG) |=> !result[WIDTH-1]);

    // R6: pass-through copies the operand
    a_r6_pass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b11) |=> (result == $past(operand) && cond_code != 2'd3));

    // R7: condition code agrees with the registered result
    a_r7_cc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond_code == 2'd0) |-> (result == '0));
    a_r7_cc_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond_code == 2'd1) |-> result[WIDTH-1]);
    a_r7_cc_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond_code == 2'd3) |-> (result == MOST_NEG));

    // R8: request only on a valid overflow
    a_r8_irq_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (out_valid && cond_code == 2'd3));

    // R9: masked overflow raises no request
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ovf_mask) |=> !irq);

    // R10: idle cycles hold the outputs
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cond_code) && !irq));
endmodule

// File: tb/test_scl_unit.sv
module test_scl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] operand = '0;
    logic        ovf_mask = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [1:0]  cond_code;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] last_res = '0;
    logic [1:0]  last_cc = '0;

    always #5 clk = ~clk;

    scl_unit #(.WIDTH(32)) i_scl_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .operand(operand), .ovf_mask(ovf_mask), .out_valid(out_valid),
        .result(result), .cond_code(cond_code), .irq(irq)
    );

    function automatic logic [31:0] m_res(logic [1:0] op, logic [31:0] x);
        case (op)
            2'b00:   return 32'd0 - x;
            2'b01:   return x[31] ? x : 32'd0 - x;
            2'b10:   return x[31] ? 32'd0 - x : x;
            default: return x;
        endcase
    endfunction

    function automatic bit m_ovf(logic [1:0] op, logic [31:0] x);
        return (x == 32'h8000_0000) && (op == 2'b00 || op == 2'b10);
    endfunction

    function automatic logic [1:0] m_cc(logic [1:0] op, logic [31:0] x);
        logic [31:0] r;
        r = m_res(op, x);
        if (m_ovf(op, x)) return 2'd3;
        if (r == 32'd0) return 2'd0;
        if (r[31]) return 2'd1;
        return 2'd2;
    endfunction

    function automatic string op_tag(logic [1:0] op);
        case (op)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] op, logic [31:0] x, logic mask);
        logic [31:0] er;
        logic [1:0]  ec;
        logic        ei;
        er = m_res(op, x);
        ec = m_cc(op, x);
        ei = m_ovf(op, x) && mask;
        in_valid = 1'b1;
        op_sel   = op;
        operand  = x;
        ovf_mask = mask;
        @(negedge clk);
        check(out_valid == 1'b1, "R2", {31'd0, out_valid}, 32'd1);
        check(result == er, op_tag(op), result, er);
        check(cond_code == ec, "R7", {30'd0, cond_code}, {30'd0, ec});
        if (m_ovf(op, x) && !mask)
            check(irq == 1'b0, "R9", {31'd0, irq}, 32'd0);
        else
            check(irq == ei, "R8", {31'd0, irq}, {31'd0, ei});
        last_res = er;
        last_cc  = ec;
    endtask

    task automatic run_idle();
        in_valid = 1'b0;
        op_sel   = 2'($urandom);
        operand  = $urandom;
        ovf_mask = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", {31'd0, out_valid}, 32'd0);
        check(result == last_res, "R10", result, last_res);
        check(cond_code == last_cc, "R10", {30'd0, cond_code}, {30'd0, last_cc});
        check(irq == 1'b0, "R10", {31'd0, irq}, 32'd0);
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom % 8)
            0:       return 32'h8000_0000;
            1:       return 32'h0000_0000;
            2:       return 32'h7FFF_FFFF;
            3:       return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
        check(irq == 1'b0, "R1", {31'd0, irq}, 32'd0);
        check(result == 32'd0, "R1", result, 32'd0);
        check(cond_code == 2'd0, "R1", {30'd0, cond_code}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);

        // directed corners for each select code and mask setting
        for (int op = 0; op < 4; op++) begin
            for (int m = 0; m < 2; m++) begin
                run_op(2'(op), 32'h8000_0000, 1'(m));
                run_op(2'(op), 32'h0000_0000, 1'(m));
                run_op(2'(op), 32'h7FFF_FFFF, 1'(m));
                run_op(2'(op), 32'hFFFF_FFFF, 1'(m));
                run_op(2'(op), 32'h0000_0001, 1'(m));
                run_idle();
            end
        end
        // back-to-back overflows: request pulses once per operation
        run_op(2'b00, 32'h8000_0000, 1'b1);
        run_op(2'b10, 32'h8000_0000, 1'b1);
        run_op(2'b00, 32'h8000_0000, 1'b0);
        run_idle();

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 5 == 0)
                run_idle();
            else
                run_op(2'($urandom), pick_operand(), 1'($urandom));
        end
        run_idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule